// File: doc/BRIEF.md
# Batch Priority Request Scheduler

This block picks which pending memory request a single bank should serve next. It watches a small request queue that lives outside it. Each slot of that queue shows a valid flag, a ready flag, the id of the issuing thread, the target row and an age. The age is a saturating counter that the queue keeps for each slot, and a larger age means an older request. The block also sees the row currently open in the bank. Each cycle it offers one slot index. When the consumer raises `issueEn` while an offer stands, that slot is taken as served.

The block groups requests into batches so that no thread can flood the bank. When no batch request is left in the queue, it marks a fresh batch. That batch holds at most `CAP` of the oldest requests from each thread. At the same moment it ranks the threads by how many requests each placed in the batch, and it keeps that ranking until the next batch forms. The choice among eligible slots looks at four things in turn: batch membership, then a hit on the open row, then thread rank, then age.

Top module: `batch_sched`

## Requirements
- R1: A grant (`grantValid` high) names only a slot whose `entValid` and `entReady` bits are both 1. `grantValid` is low whenever no such slot exists.
- R2: A batch forms in a cycle where at least one slot is valid and no valid slot is marked. In that cycle `grantValid` is low, and the new marks take effect from the next cycle. For each thread, the marked slots are its oldest valid slots. Older means a greater age; when ages are equal, the lower slot index counts as older.
- R3: An eligible slot in the current batch always wins over an eligible slot outside it, whatever the row, thread or age of the outside slot.
- R4: Among slots of equal batch membership, a row hit wins. A row hit means `openRowValid` is 1 and the slot's row equals `openRow`. When `openRowValid` is 0, no slot counts as a hit.
- R5: Next, the slot whose thread has the better rank wins. A thread that placed fewer requests in the batch ranks better. Equal counts rank the lower thread id better. Ranks are taken when the batch forms and stay fixed until the next batch forms.
- R6: Remaining ties go to the greater age, and then to the lower slot index.
- R7: A slot's mark is cleared when it is granted while `issueEn` is 1, or when the slot is invalid. While `issueEn` is 0, marks and the grant stay unchanged for unchanged inputs.
- R8: During reset no slot is marked, every thread holds rank equal to its id, and `grantValid` is low while no slot is valid.
- R9: A batch never holds more than `CAP` slots of one thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| entValid | input | DEPTH | Slot holds a request |
| entReady | input | DEPTH | Slot may be issued this cycle |
| entThread | input | DEPTH*TID_W | Thread id per slot, slot i at bits i*TID_W |
| entRow | input | DEPTH*ROW_W | Target row per slot, slot i at bits i*ROW_W |
| entAge | input | DEPTH*AGE_W | Saturating age per slot, larger is older |
| openRowValid | input | 1 | The bank has a row open |
| openRow | input | ROW_W | Row currently open in the bank |
| issueEn | input | 1 | Consumer takes the offered slot this cycle |
| grantValid | output | 1 | An offer stands |
| grantIdx | output | IDX_W | Offered slot index |

## Verification
The bench builds the block with its defaults: eight slots, four threads and a cap of two per thread. With those values a single thread can hold twice the cap, so a batch must leave some of its requests out. Two threads can also tie on intensity while a third is lighter. Because eight slots carry little state, every batch boundary, each rank tie and each equal-age tie can be set up by hand and its grant order predicted one slot at a time.

// File: rtl/batch_sched_pkg.sv
package batch_sched_pkg;

  // Strobes from control into the datapath.
  typedef struct packed {
    logic formBatch;  // mark a fresh batch at the next edge
    logic consume;    // offered slot is taken at the next edge
  } ctrl_strobe_t;

endpackage

// File: rtl/batch_sched_former.sv
// Combinational batch marking and thread ranking for a candidate batch.
module batch_sched_former #(
  parameter int DEPTH   = 8,
  parameter int THREADS = 4,
  parameter int CAP     = 2,
  parameter int AGE_W   = 4,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int RANK_W = TID_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]          entValid,
  input  logic [DEPTH*TID_W-1:0]    entThread,
  input  logic [DEPTH*AGE_W-1:0]    entAge,
  output logic [DEPTH-1:0]          formMark,
  output logic [THREADS*RANK_W-1:0] formRank
);

  logic [TID_W-1:0]  thr       [DEPTH];
  logic [AGE_W-1:0]  age       [DEPTH];
  logic [CNT_W-1:0]  olderCnt  [DEPTH];
  logic [CNT_W-1:0]  perThread [THREADS];
  logic [RANK_W-1:0] rankCalc  [THREADS];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      thr[i] = entThread[i*TID_W +: TID_W];
      age[i] = entAge[i*AGE_W +: AGE_W];
    end
  end

  // Count, per slot, how many valid slots of the same thread are older.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      olderCnt[i] = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && entValid[j] && thr[j] == thr[i] &&
            (age[j] > age[i] || (age[j] == age[i] && j < i)))
          olderCnt[i] = olderCnt[i] + CNT_W'(1);
      end
      formMark[i] = entValid[i] && (olderCnt[i] < CNT_W'(CAP));
    end
  end

  // Intensity: marked slots per thread.
  always_comb begin
    for (int t = 0; t < THREADS; t++) begin
      perThread[t] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (formMark[i] && thr[i] == TID_W'(t))
          perThread[t] = perThread[t] + CNT_W'(1);
      end
    end
  end

  // Rank position: number of threads that beat this one (0 is best).
  always_comb begin
    for (int t = 0; t < THREADS; t++) begin
      rankCalc[t] = '0;
      for (int u = 0; u < THREADS; u++) begin
        if (u != t && (perThread[u] < perThread[t] ||
                       (perThread[u] == perThread[t] && u < t)))
          rankCalc[t] = rankCalc[t] + RANK_W'(1);
      end
    end
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_rankPack
    assign formRank[t*RANK_W +: RANK_W] = rankCalc[t];
  end

endmodule

// File: rtl/batch_sched_picker.sv
// Priority selection over eligible slots.
module batch_sched_picker #(
  parameter int DEPTH   = 8,
  parameter int THREADS = 4,
  parameter int AGE_W   = 4,
  parameter int ROW_W   = 8,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int RANK_W = TID_W,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int KEY_W  = 2 + RANK_W + AGE_W
) (
  input  logic [DEPTH-1:0]          eligible,
  input  logic [DEPTH-1:0]          marked,
  input  logic [DEPTH*TID_W-1:0]    entThread,
  input  logic [DEPTH*ROW_W-1:0]    entRow,
  input  logic [DEPTH*AGE_W-1:0]    entAge,
  input  logic                      openRowValid,
  input  logic [ROW_W-1:0]          openRow,
  input  logic [THREADS*RANK_W-1:0] rankPos,
  output logic                      anyEligible,
  output logic [IDX_W-1:0]          pickIdx
);

  logic [KEY_W-1:0] key [DEPTH];
  logic [KEY_W-1:0] bestKey;

  // Key order: batch, row hit, inverted rank, age. Larger wins.
  for (genvar i = 0; i < DEPTH; i++) begin : g_key
    logic [TID_W-1:0]  slotThr;
    logic [RANK_W-1:0] slotRank;
    logic              rowHit;
    assign slotThr  = entThread[i*TID_W +: TID_W];
    assign slotRank = rankPos[slotThr*RANK_W +: RANK_W];
    assign rowHit   = openRowValid && (entRow[i*ROW_W +: ROW_W] == openRow);
    assign key[i]   = {marked[i], rowHit,
                       RANK_W'(THREADS - 1) - slotRank,
                       entAge[i*AGE_W +: AGE_W]};
  end

  // Strict comparison keeps the lower index on a full tie.
  always_comb begin
    bestKey     = '0;
    anyEligible = 1'b0;
    pickIdx     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (eligible[i] && (!anyEligible || key[i] > bestKey)) begin
        bestKey     = key[i];
        pickIdx     = IDX_W'(i);
        anyEligible = 1'b1;
      end
    end
  end

endmodule

// File: rtl/batch_sched_dp.sv
// Datapath: batch marks, held ranks, former and picker.
module batch_sched_dp
  import batch_sched_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int THREADS = 4,
  parameter int CAP     = 2,
  parameter int AGE_W   = 4,
  parameter int ROW_W   = 8,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int RANK_W = TID_W,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strobe_t           strb,
  input  logic [DEPTH-1:0]       entValid,
  input  logic [DEPTH-1:0]       entReady,
  input  logic [DEPTH*TID_W-1:0] entThread,
  input  logic [DEPTH*ROW_W-1:0] entRow,
  input  logic [DEPTH*AGE_W-1:0] entAge,
  input  logic                   openRowValid,
  input  logic [ROW_W-1:0]       openRow,
  output logic                   anyValid,
  output logic                   batchLive,
  output logic                   anyEligible,
  output logic [IDX_W-1:0]       grantIdx
);

  logic [DEPTH-1:0]          marked, markNext, formMark, consumeMask, eligible;
  logic [THREADS*RANK_W-1:0] rankPos, rankNext, formRank;

  assign eligible  = entValid & entReady;
  assign anyValid  = |entValid;
  assign batchLive = |(marked & entValid);

  batch_sched_former #(
    .DEPTH(DEPTH), .THREADS(THREADS), .CAP(CAP), .AGE_W(AGE_W)
  ) u_former (
    .entValid (entValid),
    .entThread(entThread),
    .entAge   (entAge),
    .formMark (formMark),
    .formRank (formRank)
  );

  batch_sched_picker #(
    .DEPTH(DEPTH), .THREADS(THREADS), .AGE_W(AGE_W), .ROW_W(ROW_W)
  ) u_picker (
    .eligible    (eligible),
    .marked      (marked),
    .entThread   (entThread),
    .entRow      (entRow),
    .entAge      (entAge),
    .openRowValid(openRowValid),
    .openRow     (openRow),
    .rankPos     (rankPos),
    .anyEligible (anyEligible),
    .pickIdx     (grantIdx)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      consumeMask[i] = strb.consume && (grantIdx == IDX_W'(i));
  end

  always_comb begin
    if (strb.formBatch) begin
      markNext = formMark;
      rankNext = formRank;
    end else begin
      markNext = marked & entValid & ~consumeMask;
      rankNext = rankPos;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      marked <= '0;
      for (int t = 0; t < THREADS; t++)
        rankPos[t*RANK_W +: RANK_W] <= RANK_W'(t);
    end else begin
      marked  <= markNext;
      rankPos <= rankNext;
    end
  end

  // Marks appear only out of a formation cycle.
  p_mark_from_form_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|(marked & ~$past(marked))) |-> $past(strb.formBatch));

  // A marked eligible slot is always preferred.
  p_batch_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|(marked & eligible)) |-> marked[grantIdx]);

  // Ranks move only on formation.
  p_rank_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.formBatch |=> $stable(rankPos));

  // A consumed slot loses its mark.
  p_consume_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.consume |=> !marked[$past(grantIdx)]);

  for (genvar t = 0; t < THREADS; t++) begin : g_capCheck
    logic [DEPTH-1:0] thrMask;
    for (genvar i = 0; i < DEPTH; i++) begin : g_m
      assign thrMask[i] = (entThread[i*TID_W +: TID_W] == TID_W'(t));
    end
    p_cap_r9: assert property (@(posedge clk) disable iff (!rstN)
      $countones(marked & entValid & thrMask) <= CAP);
  end

endmodule

// File: rtl/batch_sched_ctrl.sv
// Control: decides when a batch forms and when an offer is consumed.
module batch_sched_ctrl
  import batch_sched_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         anyValid,
  input  logic         batchLive,
  input  logic         anyEligible,
  input  logic         issueEn,
  output ctrl_strobe_t strb,
  output logic         grantValid
);

  always_comb begin
    strb.formBatch = anyValid && !batchLive;
    grantValid     = anyEligible && !strb.formBatch;
    strb.consume   = issueEn && grantValid;
  end

  // Nothing is consumed unless offered.
  p_consume_offered_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.consume |-> (grantValid && issueEn));

  // After formation with pending work, the batch is live next cycle.
  p_form_then_live_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.formBatch && !issueEn) |=> (batchLive || !anyValid));

endmodule

// File: rtl/batch_sched.sv
// Top: thin wrapper joining control and datapath.
module batch_sched
  import batch_sched_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int THREADS = 4,
  parameter int CAP     = 2,
  parameter int AGE_W   = 4,
  parameter int ROW_W   = 8,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DEPTH-1:0]       entValid,
  input  logic [DEPTH-1:0]       entReady,
  input  logic [DEPTH*TID_W-1:0] entThread,
  input  logic [DEPTH*ROW_W-1:0] entRow,
  input  logic [DEPTH*AGE_W-1:0] entAge,
  input  logic                   openRowValid,
  input  logic [ROW_W-1:0]       openRow,
  input  logic                   issueEn,
  output logic                   grantValid,
  output logic [IDX_W-1:0]       grantIdx
);

  ctrl_strobe_t strb;
  logic anyValid, batchLive, anyEligible;

  batch_sched_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .anyValid   (anyValid),
    .batchLive  (batchLive),
    .anyEligible(anyEligible),
    .issueEn    (issueEn),
    .strb       (strb),
    .grantValid (grantValid)
  );

  batch_sched_dp #(
    .DEPTH(DEPTH), .THREADS(THREADS), .CAP(CAP), .AGE_W(AGE_W), .ROW_W(ROW_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .entValid    (entValid),
    .entReady    (entReady),
    .entThread   (entThread),
    .entRow      (entRow),
    .entAge      (entAge),
    .openRowValid(openRowValid),
    .openRow     (openRow),
    .anyValid    (anyValid),
    .batchLive   (batchLive),
    .anyEligible (anyEligible),
    .grantIdx    (grantIdx)
  );

  p_grant_eligible_r1: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (entValid[grantIdx] && entReady[grantIdx]));

  p_reset_quiet_r8: assert property (@(posedge clk)
    (!rstN && !(|entValid)) |-> !grantValid);

endmodule

// File: tb/batch_sched_bench.sv
`timescale 1ns/1ps
module batch_sched_bench;
  localparam int DEPTH = 8, THREADS = 4, CAP = 2, AGE_W = 4, ROW_W = 8;
  localparam int TID_W = 2, IDX_W = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rstN, openRowValid, issueEn, grantValid;
  logic [ROW_W-1:0] openRow;
  logic [IDX_W-1:0] grantIdx;
  logic [DEPTH-1:0] entValid, entReady;
  logic [DEPTH*TID_W-1:0] entThread;
  logic [DEPTH*ROW_W-1:0] entRow;
  logic [DEPTH*AGE_W-1:0] entAge;

  logic             vld [DEPTH];
  logic             rdy [DEPTH];
  logic [TID_W-1:0] thr [DEPTH];
  logic [ROW_W-1:0] row [DEPTH];
  logic [AGE_W-1:0] age [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      entValid[i]                  = vld[i];
      entReady[i]                  = rdy[i];
      entThread[i*TID_W +: TID_W]  = thr[i];
      entRow[i*ROW_W +: ROW_W]     = row[i];
      entAge[i*AGE_W +: AGE_W]     = age[i];
    end
  end

  batch_sched #(
    .DEPTH(DEPTH), .THREADS(THREADS), .CAP(CAP), .AGE_W(AGE_W), .ROW_W(ROW_W)
  ) u_batch_sched (
    .clk(clk), .rstN(rstN), .entValid(entValid), .entReady(entReady),
    .entThread(entThread), .entRow(entRow), .entAge(entAge),
    .openRowValid(openRowValid), .openRow(openRow), .issueEn(issueEn),
    .grantValid(grantValid), .grantIdx(grantIdx)
  );

  int    nChk = 0, nBad = 0;
  int    expQ [$];
  string tagQ [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expectGrant(input int idx, input string req);
    expQ.push_back(idx);
    tagQ.push_back(req);
  endtask

  task automatic load(input int i, input int t, input int r, input int a, input bit rd);
    vld[i] = 1'b1; rdy[i] = rd;
    thr[i] = TID_W'(t); row[i] = ROW_W'(r); age[i] = AGE_W'(a);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // Monitor: compare each consumed grant with the scoreboard, then retire it.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && issueEn && grantValid) begin
        int g;
        g = int'(grantIdx);
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected grant", g, -1);
        end else begin
          int e;
          string tg;
          e  = expQ.pop_front();
          tg = tagQ.pop_front();
          check(g == e, tg, g, e);
        end
        @(posedge clk);
        #1 vld[g] = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog R1: actual hung expected drained");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      vld[i] = 0; rdy[i] = 0; thr[i] = '0; row[i] = '0; age[i] = '0;
    end
    rstN = 0; issueEn = 0; openRowValid = 0; openRow = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(grantValid == 1'b0, "R8 reset no grant", grantValid, 0);
    @(posedge clk); #1 rstN = 1;
    @(negedge clk);
    check(grantValid == 1'b0, "R1 idle no grant", grantValid, 0);

    // A: cap, formation gap, rank, batch over unmarked hit.
    @(posedge clk); #1;
    openRowValid = 1; openRow = 8'h30;
    load(0, 0, 8'h10, 5, 1); load(1, 0, 8'h10, 9, 1);
    load(2, 0, 8'h10, 7, 1); load(3, 0, 8'h10, 1, 1);
    load(4, 1, 8'h20, 2, 1);
    @(negedge clk);
    check(grantValid == 1'b0, "R2 formation cycle", grantValid, 0);
    @(negedge clk);
    check(grantValid && grantIdx == 3'd4, "R5 lighter thread first", grantIdx, 4);
    @(posedge clk); #1 load(5, 2, 8'h30, 15, 1);
    @(negedge clk);
    check(grantValid && grantIdx == 3'd4, "R3 unmarked hit loses", grantIdx, 4);
    @(posedge clk); #1;
    check(grantValid && grantIdx == 3'd4, "R7 hold without issue", grantIdx, 4);
    expectGrant(4, "R5"); expectGrant(1, "R6"); expectGrant(2, "R6");
    expectGrant(5, "R9"); expectGrant(0, "R6"); expectGrant(3, "R6");
    issueEn = 1;
    waitDrain();

    // B: hit over rank, rank tie to lower thread id.
    openRow = 8'h50;
    expectGrant(0, "R4"); expectGrant(2, "R5"); expectGrant(3, "R5");
    expectGrant(1, "R5");
    load(0, 1, 8'h50, 3, 1); load(1, 1, 8'h51, 8, 1);
    load(2, 2, 8'h51, 2, 1); load(3, 3, 8'h51, 9, 1);
    waitDrain();

    // C: age order, equal ages resolved by index.
    expectGrant(7, "R6"); expectGrant(4, "R6"); expectGrant(5, "R2");
    load(4, 0, 8'h60, 5, 1); load(5, 0, 8'h60, 5, 1); load(7, 0, 8'h60, 11, 1);
    waitDrain();

    // D: readiness gating.
    expectGrant(1, "R1");
    load(0, 0, 8'h60, 9, 0); load(1, 0, 8'h60, 2, 1);
    waitDrain();
    @(negedge clk);
    check(grantValid == 1'b0, "R1 not ready no grant", grantValid, 0);
    @(posedge clk); #1;
    expectGrant(0, "R1");
    rdy[0] = 1;
    waitDrain();

    // E: closed row gives no hit.
    openRowValid = 0;
    expectGrant(3, "R4"); expectGrant(2, "R4");
    load(2, 1, 8'h50, 1, 1); load(3, 1, 8'h51, 5, 1);
    waitDrain();

    check(expQ.size() == 0, "R7 all grants seen", expQ.size(), 0);
    summary();
    $finish;
  end

endmodule